// File: doc/BRIEF.md
# Fuse Word Lock Bank

This block keeps the lock state that decides whether an operation on one word of a fuse array may proceed. Each fuse word owns one bit in each of three sticky bitmaps: one blocks reloading the word into its shadow copy, one blocks rewriting the shadow copy, and one blocks burning the fuse. A fourth bitmap is read-only. It shows the words that are already locked for good in the fuse array and enters the block as an input vector. A small control register holds three chip-wide locks: upper region, debug configuration and all programming. A further bitmap opens individual upper-region words to non-secure masters.

Software sets locks through a simple register port. Any set bit stays set until reset. The fuse controller asks for permission on a separate check port, giving a word index, an operation code and the security attribute of the requester. Within the same cycle it gets back either grant or deny. The block does not execute any fuse command itself.

Top module: `fuse_lock_bank`

## Requirements
- R1: Register map by byte address, with bits [1:0] ignored. Bank b of a word bitmap is at group base + 4*b. Word i sits in bank i>>5 at bit i&31. Group bases: 0x00 shadow-read lock, 0x10 shadow-write lock, 0x20 program lock, 0x30 permanent lock, 0x50 non-secure grant. The non-secure grant bank is (i-UPPER_BASE)>>5 and its bit is (i-UPPER_BASE)&31. The global lock register is at 0x40 and the configuration-done register at 0x44.
- R2: In every writable lock register, writing a 1 sets the bit and writing a 0 changes nothing. Only reset clears a bit, and everything reads 0 after reset.
- R3: A check is denied when the word's lock bit is set in the bitmap for its operation. Operation codes: 0 shadow read uses the shadow-read lock, 1 shadow write uses the shadow-write lock, 2 program uses the program lock or the permanent lock.
- R4: The global lock register uses three bits. Bit 0 denies programming of words at or above UPPER_BASE. Bit 2 denies operation code 3 (debug configuration), whatever the index. Bit 4 denies all programming. The other bits read 0.
- R5: A non-secure check of a word index below UPPER_BASE is never denied for security reasons. A non-secure check of an upper word is denied unless its non-secure grant bit is set. Secure checks ignore the grant bitmap.
- R6: Grant bits change only on a secure write made while configuration-done is clear. A secure write with bit 0 set at 0x44 sets configuration-done for good. Non-secure writes to either register have no effect.
- R7: A word operation (codes 0 to 2) whose index is above NUM_WORDS-1 is denied, even when the requester is secure.
- R8: chk_grant and chk_deny answer in the same cycle as chk_valid, and exactly one of them is high. Both are low when no check is requested.
- R9: The permanent-lock registers read back perm_lock_i, and writes to them are ignored.
- R10: Unmapped addresses read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_secure | input | 1 | Register access comes from a secure master |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| perm_lock_i | input | NUM_WORDS | Words permanently locked in the fuse array |
| chk_valid | input | 1 | Operation check request |
| chk_index | input | 8 | Fuse word index to check |
| chk_op | input | 2 | Operation code (0 read, 1 write, 2 program, 3 debug) |
| chk_secure | input | 1 | Checked requester is secure |
| chk_grant | output | 1 | Operation allowed |
| chk_deny | output | 1 | Operation refused |

## Verification
Suppose a lock bit is decoded to the wrong bank or bit, or a sticky bit falls. The error shows up at the next read of that register, and on the first check of the affected word, which answers combinationally in the same cycle. A grant bit that can still change after configuration-done, or that a non-secure write can set, shows up as a non-secure check of an upper word that grants where it should deny. A mistake in the global lock bits shows up when a program or debug check is not refused. The random phase runs writes and checks interleaved, so a corrupted state normally surfaces within a few transactions of its cause.

// File: rtl/fuse_lock_pkg.sv
package fuse_lock_pkg;

    typedef enum logic [1:0] {
        OP_SHADOW_RD = 2'd0,
        OP_SHADOW_WR = 2'd1,
        OP_PROGRAM   = 2'd2,
        OP_DEBUG_CFG = 2'd3
    } fl_op_e;

    // register groups, selected by address bits [7:4]
    localparam logic [3:0] GRP_RD   = 4'h0;
    localparam logic [3:0] GRP_WR   = 4'h1;
    localparam logic [3:0] GRP_PG   = 4'h2;
    localparam logic [3:0] GRP_PERM = 4'h3;
    localparam logic [3:0] GRP_CTRL = 4'h4;
    localparam logic [3:0] GRP_NS   = 4'h5;

    // bit positions in the global lock register
    localparam int GL_UPPER_BIT = 0;
    localparam int GL_DEBUG_BIT = 2;
    localparam int GL_PROG_BIT  = 4;

    typedef struct packed {
        logic upper;
        logic debug;
        logic prog;
    } fl_glob_t;

endpackage

// File: rtl/fuse_lock_regs.sv
module fuse_lock_regs
    import fuse_lock_pkg::*;
#(
    parameter int NUM_WORDS  = 96,
    parameter int UPPER_BASE = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wen,
    input  logic [7:0]                        addr,
    input  logic [31:0]                       wdata,
    input  logic                              secure,
    input  logic [NUM_WORDS-1:0]              perm_i,
    output logic [31:0]                       rdata,
    output logic [NUM_WORDS-1:0]              rd_map,
    output logic [NUM_WORDS-1:0]              wr_map,
    output logic [NUM_WORDS-1:0]              pg_map,
    output logic [NUM_WORDS-UPPER_BASE-1:0]   ns_map,
    output fl_glob_t                          glob
);
    localparam int BANKS     = (NUM_WORDS + 31) / 32;
    localparam int NUM_UPPER = NUM_WORDS - UPPER_BASE;
    localparam int NS_BANKS  = (NUM_UPPER + 31) / 32;
    localparam int MAP_W     = BANKS * 32;
    localparam int NS_W      = NS_BANKS * 32;
    localparam logic [MAP_W-1:0] MAP_MASK = {MAP_W{1'b1}} >> (MAP_W - NUM_WORDS);
    localparam logic [NS_W-1:0]  NS_MASK  = {NS_W{1'b1}} >> (NS_W - NUM_UPPER);

    typedef struct packed {
        logic [MAP_W-1:0] rd;
        logic [MAP_W-1:0] wr;
        logic [MAP_W-1:0] pg;
        logic [NS_W-1:0]  ns;
        fl_glob_t         gl;
        logic             done;
    } state_t;

    state_t s_d, s_q;

    logic [3:0]       grp;
    logic [1:0]       slot;
    logic [MAP_W-1:0] perm_pad;
    logic             unused_addr;

    assign grp         = addr[7:4];
    assign slot        = addr[3:2];
    assign unused_addr = ^addr[1:0];
    assign perm_pad    = MAP_W'(perm_i);

    // next state: write-one-to-set, nothing ever clears
    always_comb begin
        s_d = s_q;
        if (wen) begin
            for (int b = 0; b < BANKS; b++) begin
                if (slot == 2'(b)) begin
                    if (grp == GRP_RD) s_d.rd[b*32 +: 32] = s_q.rd[b*32 +: 32] | wdata;
                    if (grp == GRP_WR) s_d.wr[b*32 +: 32] = s_q.wr[b*32 +: 32] | wdata;
                    if (grp == GRP_PG) s_d.pg[b*32 +: 32] = s_q.pg[b*32 +: 32] | wdata;
                end
            end
            for (int b = 0; b < NS_BANKS; b++) begin
                if (grp == GRP_NS && slot == 2'(b) && secure && !s_q.done)
                    s_d.ns[b*32 +: 32] = s_q.ns[b*32 +: 32] | wdata;
            end
            if (grp == GRP_CTRL && slot == 2'd0) begin
                s_d.gl.upper = s_q.gl.upper | wdata[GL_UPPER_BIT];
                s_d.gl.debug = s_q.gl.debug | wdata[GL_DEBUG_BIT];
                s_d.gl.prog  = s_q.gl.prog  | wdata[GL_PROG_BIT];
            end
            if (grp == GRP_CTRL && slot == 2'd1 && secure)
                s_d.done = s_q.done | wdata[0];
        end
        s_d.rd = s_d.rd & MAP_MASK;
        s_d.wr = s_d.wr & MAP_MASK;
        s_d.pg = s_d.pg & MAP_MASK;
        s_d.ns = s_d.ns & NS_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // read mux
    always_comb begin
        rdata = '0;
        case (grp)
            GRP_RD, GRP_WR, GRP_PG, GRP_PERM: begin
                for (int b = 0; b < BANKS; b++) begin
                    if (slot == 2'(b)) begin
                        case (grp)
                            GRP_RD:  rdata = s_q.rd[b*32 +: 32];
                            GRP_WR:  rdata = s_q.wr[b*32 +: 32];
                            GRP_PG:  rdata = s_q.pg[b*32 +: 32];
                            default: rdata = perm_pad[b*32 +: 32];
                        endcase
                    end
                end
            end
            GRP_CTRL: begin
                if (slot == 2'd0) begin
                    rdata[GL_UPPER_BIT] = s_q.gl.upper;
                    rdata[GL_DEBUG_BIT] = s_q.gl.debug;
                    rdata[GL_PROG_BIT]  = s_q.gl.prog;
                end else if (slot == 2'd1) begin
                    rdata[0] = s_q.done;
                end
            end
            GRP_NS: begin
                for (int b = 0; b < NS_BANKS; b++)
                    if (slot == 2'(b)) rdata = s_q.ns[b*32 +: 32];
            end
            default: rdata = '0;
        endcase
    end

    assign rd_map = s_q.rd[NUM_WORDS-1:0];
    assign wr_map = s_q.wr[NUM_WORDS-1:0];
    assign pg_map = s_q.pg[NUM_WORDS-1:0];
    assign ns_map = s_q.ns[NUM_UPPER-1:0];
    assign glob   = s_q.gl;

    AST_RD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(s_q.rd) & ~s_q.rd) == '0); // R2
    AST_WR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(s_q.wr) & ~s_q.wr) == '0); // R2
    AST_PG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(s_q.pg) & ~s_q.pg) == '0); // R2
    AST_GRANT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> $stable(s_q.ns)); // R6
    AST_GRANT_NS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wen && !secure) |=> $stable(s_q.ns)); // R6
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> s_q.done); // R6

endmodule

// File: rtl/fuse_lock_index.sv
module fuse_lock_index #(
    parameter int NUM_WORDS  = 96,
    parameter int UPPER_BASE = 32,
    parameter int IDX_W      = 8
) (
    input  logic [IDX_W-1:0]                          idx,
    output logic                                      in_range,
    output logic                                      is_upper,
    output logic [$clog2(NUM_WORDS)-1:0]              word_idx,
    output logic [$clog2(NUM_WORDS-UPPER_BASE)-1:0]   up_idx
);
    localparam int MAX_INDEX = NUM_WORDS - 1;
    localparam int WORD_W    = $clog2(NUM_WORDS);
    localparam int UP_W      = $clog2(NUM_WORDS - UPPER_BASE);

    logic [IDX_W-1:0] up_off;

    assign in_range = idx <= IDX_W'(MAX_INDEX);
    assign is_upper = in_range && (idx >= IDX_W'(UPPER_BASE));
    assign up_off   = idx - IDX_W'(UPPER_BASE);
    // bank = idx >> 5, bit = idx & 31 : flat position bank*32 + bit
    assign word_idx = in_range ? WORD_W'(idx) : '0;
    assign up_idx   = is_upper ? UP_W'(up_off) : '0;

endmodule

// File: rtl/fuse_lock_gate.sv
module fuse_lock_gate
    import fuse_lock_pkg::*;
(
    input  logic     valid,
    input  fl_op_e   op,
    input  logic     secure,
    input  logic     in_range,
    input  logic     is_upper,
    input  logic     rd_hit,
    input  logic     wr_hit,
    input  logic     pg_hit,
    input  logic     perm_hit,
    input  logic     ns_open,
    input  fl_glob_t glob,
    output logic     grant,
    output logic     deny
);
    logic blocked;

    always_comb begin
        blocked = 1'b0;
        if (op == OP_DEBUG_CFG) begin
            blocked = glob.debug;
        end else if (!in_range) begin
            blocked = 1'b1;
        end else begin
            if (!secure && is_upper && !ns_open) blocked = 1'b1;
            case (op)
                OP_SHADOW_RD: if (rd_hit) blocked = 1'b1;
                OP_SHADOW_WR: if (wr_hit) blocked = 1'b1;
                OP_PROGRAM:   if (pg_hit || perm_hit || glob.prog || (glob.upper && is_upper))
                                  blocked = 1'b1;
                default:      blocked = blocked;
            endcase
        end
    end

    assign deny  = valid &  blocked;
    assign grant = valid & ~blocked;

endmodule

// File: rtl/fuse_lock_bank.sv
module fuse_lock_bank
    import fuse_lock_pkg::*;
#(
    parameter int NUM_WORDS  = 96,
    parameter int UPPER_BASE = 32,
    parameter int IDX_W      = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wen,
    input  logic [7:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    input  logic                 reg_secure,
    output logic [31:0]          reg_rdata,
    input  logic [NUM_WORDS-1:0] perm_lock_i,
    input  logic                 chk_valid,
    input  logic [IDX_W-1:0]     chk_index,
    input  logic [1:0]           chk_op,
    input  logic                 chk_secure,
    output logic                 chk_grant,
    output logic                 chk_deny
);
    localparam int NUM_UPPER = NUM_WORDS - UPPER_BASE;
    localparam int WORD_W    = $clog2(NUM_WORDS);
    localparam int UP_W      = $clog2(NUM_UPPER);
    localparam int MAX_INDEX = NUM_WORDS - 1;

    logic [NUM_WORDS-1:0] rd_map, wr_map, pg_map;
    logic [NUM_UPPER-1:0] ns_map;
    fl_glob_t             glob;
    logic                 in_range, is_upper;
    logic [WORD_W-1:0]    word_idx;
    logic [UP_W-1:0]      up_idx;
    fl_op_e               op;

    assign op = fl_op_e'(chk_op);

    fuse_lock_regs #(.NUM_WORDS(NUM_WORDS), .UPPER_BASE(UPPER_BASE)) regs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wen    (reg_wen),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .secure (reg_secure),
        .perm_i (perm_lock_i),
        .rdata  (reg_rdata),
        .rd_map (rd_map),
        .wr_map (wr_map),
        .pg_map (pg_map),
        .ns_map (ns_map),
        .glob   (glob)
    );

    fuse_lock_index #(.NUM_WORDS(NUM_WORDS), .UPPER_BASE(UPPER_BASE), .IDX_W(IDX_W)) index_i (
        .idx      (chk_index),
        .in_range (in_range),
        .is_upper (is_upper),
        .word_idx (word_idx),
        .up_idx   (up_idx)
    );

    fuse_lock_gate gate_i (
        .valid    (chk_valid),
        .op       (op),
        .secure   (chk_secure),
        .in_range (in_range),
        .is_upper (is_upper),
        .rd_hit   (rd_map[word_idx]),
        .wr_hit   (wr_map[word_idx]),
        .pg_hit   (pg_map[word_idx]),
        .perm_hit (perm_lock_i[word_idx]),
        .ns_open  (ns_map[up_idx]),
        .glob     (glob),
        .grant    (chk_grant),
        .deny     (chk_deny)
    );

    AST_RANGE_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && op != OP_DEBUG_CFG && chk_index > IDX_W'(MAX_INDEX)) |-> chk_deny); // R7
    AST_GLOBAL_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && op == OP_PROGRAM && glob.prog) |-> chk_deny); // R4
    AST_NS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && !chk_secure && op != OP_DEBUG_CFG && chk_index >= IDX_W'(UPPER_BASE)
         && chk_index <= IDX_W'(MAX_INDEX) && !ns_map[up_idx]) |-> chk_deny); // R5
    AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |-> $onehot({chk_grant, chk_deny})); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |-> !(chk_grant || chk_deny)); // R8

endmodule

// File: tb/fuse_lock_bank_tb_top.sv
`timescale 1ns/1ps
module fuse_lock_bank_tb_top;
    localparam int NW = 96;
    localparam int UB = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_secure = 1'b0;
    logic [31:0] reg_rdata;
    logic [NW-1:0] perm_lock_i = '0;
    logic        chk_valid = 1'b0;
    logic [7:0]  chk_index = '0;
    logic [1:0]  chk_op = '0;
    logic        chk_secure = 1'b0;
    logic        chk_grant, chk_deny;

    always #4 clk = ~clk;

    fuse_lock_bank dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_secure(reg_secure), .reg_rdata(reg_rdata),
        .perm_lock_i(perm_lock_i), .chk_valid(chk_valid), .chk_index(chk_index),
        .chk_op(chk_op), .chk_secure(chk_secure), .chk_grant(chk_grant), .chk_deny(chk_deny)
    );

    // reference model
    logic [NW-1:0]    m_rd = '0, m_wr = '0, m_pg = '0;
    logic [NW-UB-1:0] m_ns = '0;
    logic m_up = 0, m_dbg = 0, m_prg = 0, m_done = 0;
    int n_chk = 0, n_fail = 0;

    function automatic logic [31:0] exp_rdata(input logic [7:0] a);
        int s = int'(a[3:2]);
        case (a[7:4])
            4'h0: return (s < 3) ? m_rd[s*32 +: 32] : 32'h0;
            4'h1: return (s < 3) ? m_wr[s*32 +: 32] : 32'h0;
            4'h2: return (s < 3) ? m_pg[s*32 +: 32] : 32'h0;
            4'h3: return (s < 3) ? perm_lock_i[s*32 +: 32] : 32'h0;
            4'h4: if (s == 0) return {27'b0, m_prg, 1'b0, m_dbg, 1'b0, m_up};
                  else if (s == 1) return {31'b0, m_done};
                  else return 32'h0;
            4'h5: return (s < 2) ? m_ns[s*32 +: 32] : 32'h0;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic exp_deny(input int idx, input int op, input logic sec);
        if (op == 3) return m_dbg;
        if (idx > NW - 1) return 1'b1;
        if (!sec && idx >= UB && !m_ns[idx-UB]) return 1'b1;
        case (op)
            0: return m_rd[idx];
            1: return m_wr[idx];
            default: return m_pg[idx] | perm_lock_i[idx] | m_prg | (m_up && idx >= UB);
        endcase
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [31:0] d, input logic sec);
        int s = int'(a[3:2]);
        case (a[7:4])
            4'h0: if (s < 3) m_rd[s*32 +: 32] = m_rd[s*32 +: 32] | d;
            4'h1: if (s < 3) m_wr[s*32 +: 32] = m_wr[s*32 +: 32] | d;
            4'h2: if (s < 3) m_pg[s*32 +: 32] = m_pg[s*32 +: 32] | d;
            4'h4: if (s == 0) begin
                      m_up = m_up | d[0]; m_dbg = m_dbg | d[2]; m_prg = m_prg | d[4];
                  end else if (s == 1 && sec) m_done = m_done | d[0];
            4'h5: if (s < 2 && sec && !m_done) m_ns[s*32 +: 32] = m_ns[s*32 +: 32] | d;
            default: ;
        endcase
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d, input logic sec);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d; reg_secure = sec;
        @(posedge clk);
        #1;
        reg_wen = 1'b0;
        model_write(a, d, sec);
    endtask

    task automatic reg_check(input string tag, input logic [7:0] a);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp_rdata(a));
    endtask

    task automatic op_check(input string tag, input int idx, input int op, input logic sec);
        logic e;
        @(negedge clk);
        chk_valid = 1'b1; chk_index = 8'(idx); chk_op = 2'(op); chk_secure = sec;
        #1;
        e = exp_deny(idx, op, sec);
        check(tag, {30'b0, chk_grant, chk_deny}, {30'b0, ~e, e});
        chk_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // reset state
        reg_check("R2 reset rd bank0", 8'h00);
        reg_check("R2 reset pg bank2", 8'h28);
        reg_check("R4 reset global", 8'h40);
        reg_check("R6 reset done", 8'h44);
        op_check("R3 reset read granted", 0, 0, 1'b1);

        // per-word decoding and sticky set
        reg_write(8'h04, 32'h0000_0020, 1'b0);
        reg_check("R1 rd bank1 readback", 8'h04);
        op_check("R3 read word37 locked", 37, 0, 1'b1);
        op_check("R3 read word36 open", 36, 0, 1'b1);
        op_check("R3 write word37 open", 37, 1, 1'b1);
        reg_write(8'h04, 32'h0, 1'b1);
        reg_check("R2 zero write keeps bit", 8'h04);
        op_check("R2 word37 still locked", 37, 0, 1'b1);
        reg_write(8'h18, 32'h8000_0000, 1'b1);
        op_check("R3 write word95 locked", 95, 1, 1'b1);
        reg_write(8'h20, 32'h0000_0001, 1'b1);
        op_check("R3 program word0 locked", 0, 2, 1'b1);

        // permanent map is read only
        perm_lock_i[70] = 1'b1;
        reg_check("R9 perm readback", 8'h38);
        reg_write(8'h38, 32'hFFFF_FFFF, 1'b1);
        reg_check("R9 perm write ignored", 8'h38);
        op_check("R9 R3 program word70 perm", 70, 2, 1'b1);
        op_check("R9 program word71 open", 71, 2, 1'b1);

        // non-secure filter
        op_check("R5 ns lower open", 10, 0, 1'b0);
        op_check("R5 ns upper denied", 50, 0, 1'b0);
        op_check("R5 secure upper open", 50, 0, 1'b1);
        reg_write(8'h50, 32'h0004_0000, 1'b1);
        reg_check("R1 R6 ns bank0 readback", 8'h50);
        op_check("R5 ns word50 granted", 50, 0, 1'b0);
        reg_write(8'h54, 32'h0000_0001, 1'b0);
        reg_check("R6 ns write ignored", 8'h54);
        op_check("R6 ns word64 still denied", 64, 1, 1'b0);

        // unmapped
        reg_write(8'h70, 32'hFFFF_FFFF, 1'b1);
        reg_check("R10 unmapped 0x70", 8'h70);
        reg_check("R10 unmapped 0x0C", 8'h0C);
        reg_check("R10 unmapped 0x48", 8'h48);

        // random phase
        for (int it = 0; it < 600; it++) begin
            int r = int'($urandom % 4);
            if (r == 0) begin
                logic [7:0] a;
                int g = int'($urandom % 5);
                int s = int'($urandom % 3);
                case (g)
                    0: a = 8'(s * 4);
                    1: a = 8'(8'h10 + s * 4);
                    2: a = 8'(8'h20 + s * 4);
                    3: a = 8'(8'h30 + s * 4);
                    default: a = 8'(8'h50 + (s % 2) * 4);
                endcase
                reg_write(a, 32'h1 << ($urandom % 32), 1'($urandom % 2));
            end else if (r == 1) begin
                reg_check("R1 R2 random readback", 8'(($urandom % 24) * 4));
            end else begin
                op_check("R3 R5 R7 random check", int'($urandom % 104), int'($urandom % 3),
                         1'($urandom % 2));
            end
        end

        // configuration done freezes grants
        reg_write(8'h44, 32'h1, 1'b0);
        reg_check("R6 ns done ignored", 8'h44);
        reg_write(8'h44, 32'h1, 1'b1);
        reg_check("R6 done set", 8'h44);
        reg_write(8'h54, 32'hFFFF_FFFF, 1'b1);
        reg_check("R6 grant frozen", 8'h54);

        // range
        op_check("R7 index 96 denied", 96, 0, 1'b1);
        op_check("R7 index 200 denied", 200, 1, 1'b1);
        op_check("R7 index 255 program denied", 255, 2, 1'b1);

        // idle
        @(negedge clk);
        chk_valid = 1'b0; chk_index = 8'd3;
        #1;
        check("R8 idle outputs low", {30'b0, chk_grant, chk_deny}, 32'h0);

        // global locks
        op_check("R4 debug open", 0, 3, 1'b0);
        reg_write(8'h40, 32'h0000_0001, 1'b0);
        reg_check("R4 global upper readback", 8'h40);
        op_check("R4 upper program denied", 40, 2, 1'b1);
        op_check("R4 lower program open", 10, 2, 1'b1);
        op_check("R4 upper read unaffected", 90, 0, 1'b1);
        reg_write(8'h40, 32'hFFFF_FFFF, 1'b1);
        reg_check("R4 global only three bits", 8'h40);
        op_check("R4 debug denied", 5, 3, 1'b1);
        op_check("R4 debug denied any index", 250, 3, 1'b0);
        op_check("R4 lower program denied", 10, 2, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule